// File: doc/BRIEF.md
# Memory bank chip-select controller

This block receives the address and function code of each bus access, works out which of its memory banks the access falls into, and then plays out the strobe pattern for that bank. A static (SRAM-style) bank gets one chip select. A DRAM bank gets a row strobe, a column strobe and a shared row/column address-multiplexer select. Every bank carries a base word and an option word, supplied as static configuration vectors. Timing is placed on a half-clock grid. The block runs on a phase clock `pclk`, and the bus clock `bclk` toggles once per phase, so two phases make one bus clock.

An access is offered by pulsing `start` for one `pclk` edge. The block takes the access only on an edge where `bclk` is low and no cycle is running. A bank may lengthen its cycle with a relax option. It may also accept four-beat bursts, and while a burst runs the block drives the long-word offset on `badr`. The access address reaches the block in two parts. `addr_hi` holds address bits 31..11. `addr_lw` holds address bits 3..2.

Top module: `bank_cs_ctrl`

## Requirements
- R1: A bank hits when it is valid and `addr_hi[16:0]` equals base bits [16:0]. For an external master (`ext_master`=1) with `ext_we`=0, `addr_hi[20:17]` must also equal base bits [20:17]. In every other case those upper four bits are not compared. Base word layout per bank (29 bits): [28:8] base, [7:4] function code, [3] burst enable, [2] relax, [1] DRAM kind, [0] valid.
- R2: The 4-bit function code `fc` must equal the bank's code only on the bit positions set in the mask. Option word layout per bank (10 bits): [9] sync, [8] early chip-select negation, [7:4] cycle length `len`, [3:0] code mask.
- R3: When several banks hit, the lowest-numbered bank gets the access, and only one chip select is ever asserted at a time.
- R4: After reset, and after an access that hits no bank, every strobe (`cs_n`, `ras_n`, `cas_n`, `amux_n`, `burst_ack_n`) stays high. An access that hits no bank sets `nomatch`, and the next access that does hit clears it.
- R5: Phase k is the state after the k-th `pclk` edge, counting the accepting edge as k=0. A cycle lasts T = 4 + 2·len phases. On an SRAM bank the chip select is low for 1 ≤ k < T, or for 1 ≤ k < T−1 when early negation is set.
- R6: With relax set on an SRAM bank, T grows by 2 and the chip select first goes low at k=2.
- R7: On a DRAM bank the row strobe is low from k=1, the mux select from k=2 and the column strobe from k=3, each until T. With relax set these become k=2, 4 and 5, and T grows by exactly 2.
- R8: With `burst_req`=1 on a bank that has burst enable set, `burst_ack_n` is low for the whole cycle and T grows by 6. `badr` starts at `addr_lw` and steps by 1 modulo 4 at phases T−6, T−4 and T−2.
- R9: With `burst_req`=1 on a bank whose burst enable is clear, `burst_ack_n` stays high and the cycle has single-transfer length.
- R10: An external master accessing an SRAM bank whose sync bit is clear gets neither the relax nor the early-negation behaviour.
- R11: `cfg_err[i]` is high exactly when bank i has relax and early negation set and `len` is zero.
- R12: A `start` pulse that arrives while a cycle is running is ignored. It does not disturb the strobes or `nomatch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Phase clock, two phases per bus clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Access request, sampled when `bclk` is low |
| addr_hi | input | 21 | Access address bits 31..11 |
| addr_lw | input | 2 | Access long-word offset (address bits 3..2) |
| fc | input | 4 | Access function code |
| ext_master | input | 1 | Access comes from an external master |
| ext_we | input | 1 | External master drives the byte write-enable lines |
| burst_req | input | 1 | Access requests a four-beat burst |
| cfg_br | input | NB*29 | Base words, bank i in bits [i*29 +: 29] |
| cfg_or | input | NB*10 | Option words, bank i in bits [i*10 +: 10] |
| bclk | output | 1 | Bus clock, toggles each phase |
| cs_n | output | NB | Chip selects for SRAM banks |
| ras_n | output | NB | Row strobes for DRAM banks |
| cas_n | output | NB | Column strobes for DRAM banks |
| amux_n | output | 1 | Row/column address mux select, low selects column |
| burst_ack_n | output | 1 | Burst acknowledge |
| badr | output | 2 | Generated long-word offset |
| nomatch | output | 1 | Last accepted access hit no bank |
| cfg_err | output | NB | Per-bank illegal option combination |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a running cycle and would, if taken, miss every bank. Only `nomatch` and the strobe trains show that it was dropped. The stimulus creates it during a sweep over function codes, master kinds and addresses. In one slice of that sweep, a second `start` pulse is sent one phase into the cycle with an address that matches no bank, on a `bclk`-low edge. The phase-by-phase strobe check then runs to the end of the cycle. The sweep places two banks on the same base so that the function-code mask decides between them, which also exercises priority.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int LEN_W  = 4;
  localparam int FC_W   = 4;
  localparam int BASE_W = 21;
  localparam int BR_W   = BASE_W + FC_W + 4;
  localparam int OR_W   = FC_W + LEN_W + 2;
  localparam int MAX_PH = 2 * (2 + (2 ** LEN_W - 1) + 1 + 3);
  localparam int PH_W   = $clog2(MAX_PH + 1);

  typedef enum logic [1:0] {ST_SEL, ST_MUX, ST_COL} strobe_t;

  typedef struct packed {
    logic             dram;
    logic             relax;
    logic             csneg;
    logic             sync;
    logic             burst;
    logic [LEN_W-1:0] len;
  } mode_t;

  // Number of phases in one cycle.
  function automatic logic [PH_W-1:0] cycle_phases(input logic [LEN_W-1:0] len,
                                                   input logic rlx, input logic bst);
    return PH_W'(4 + 2 * int'(len) + (rlx ? 2 : 0) + (bst ? 6 : 0));
  endfunction

  // First phase in which a strobe kind is active.
  function automatic logic [PH_W-1:0] first_phase(input strobe_t which, input logic rlx);
    case (which)
      ST_MUX:  return PH_W'(2 + 2 * int'(rlx));
      ST_COL:  return PH_W'(3 + 2 * int'(rlx));
      default: return PH_W'(1 + int'(rlx));
    endcase
  endfunction

  // Beat number 0..3 inside a burst cycle of tot phases.
  function automatic logic [1:0] burst_beat(input logic [PH_W-1:0] ph, input logic [PH_W-1:0] tot);
    logic [PH_W-1:0] d;
    d = ph - (tot - PH_W'(6));
    if (ph >= tot - PH_W'(6)) return 2'(d >> 1) + 2'd1;
    return 2'd0;
  endfunction
endpackage

// File: rtl/bcs_bank_match.sv
module bcs_bank_match
  import bcs_pkg::*;
(
  input  logic [BR_W-1:0]   br,
  input  logic [OR_W-1:0]   opt,
  input  logic [BASE_W-1:0] addr_hi,
  input  logic [FC_W-1:0]   fc,
  input  logic              full_cmp,
  output logic              hit,
  output logic              cfg_err,
  output mode_t             mode
);
  logic [BASE_W-1:0] base;
  logic [FC_W-1:0]   bfc, fcm;
  logic              lo_eq, hi_eq, fc_eq;

  assign base = br[BR_W-1 -: BASE_W];
  assign bfc  = br[7:4];
  assign fcm  = opt[3:0];

  assign mode.burst = br[3];
  assign mode.relax = br[2];
  assign mode.dram  = br[1];
  assign mode.sync  = opt[9];
  assign mode.csneg = opt[8];
  assign mode.len   = opt[7:4];

  assign lo_eq = addr_hi[BASE_W-5:0] == base[BASE_W-5:0];
  assign hi_eq = addr_hi[BASE_W-1 -: 4] == base[BASE_W-1 -: 4];
  assign fc_eq = ((fc ^ bfc) & fcm) == '0;
  assign hit   = br[0] && lo_eq && (hi_eq || !full_cmp) && fc_eq;

  assign cfg_err = mode.relax && mode.csneg && (mode.len == '0);
endmodule

// File: rtl/bcs_pick.sv
module bcs_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (req[i]) idx = IDX_W'(i);
  end
  assign any = |req;
endmodule

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
#(
  parameter int NB = 4,
  parameter int IDX_W = 2
) (
  input  logic             pclk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             any_hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  mode_t            hit_mode,
  input  logic             ext_master,
  input  logic             burst_req,
  input  logic [1:0]       addr_lw,
  output logic             bclk,
  output logic [NB-1:0]    cs_n,
  output logic [NB-1:0]    ras_n,
  output logic [NB-1:0]    cas_n,
  output logic             amux_n,
  output logic             burst_ack_n,
  output logic [1:0]       badr,
  output logic             nomatch
);
  logic             busy, dram, rlx, neg, bst;
  logic [PH_W-1:0]  ph;
  logic [IDX_W-1:0] bank;
  logic [LEN_W-1:0] len;
  logic [1:0]       off;

  // named events
  logic            accept_ev, take_ev, miss_ev, end_ev, quiet_ev;
  logic [PH_W-1:0] tot;
  assign accept_ev = start && !busy && !bclk;
  assign take_ev   = accept_ev && any_hit;
  assign miss_ev   = accept_ev && !any_hit;
  assign tot       = cycle_phases(len, rlx, bst);
  assign end_ev    = busy && (ph == tot - PH_W'(1));
  assign quiet_ev  = ext_master && !hit_mode.sync && !hit_mode.dram;

  logic             n_busy, n_dram, n_rlx, n_neg, n_bst;
  logic [PH_W-1:0]  n_ph, n_tot;
  logic [IDX_W-1:0] n_bank;
  logic [LEN_W-1:0] n_len;
  logic [1:0]       n_off;
  logic             act_sel, act_row, act_mux, act_col;
  logic [NB-1:0]    bank_1h;

  always_comb begin
    n_busy = busy; n_ph = ph; n_bank = bank; n_dram = dram;
    n_rlx = rlx; n_neg = neg; n_bst = bst; n_len = len; n_off = off;
    if (take_ev) begin
      n_busy = 1'b1;
      n_ph   = '0;
      n_bank = hit_idx;
      n_dram = hit_mode.dram;
      n_rlx  = hit_mode.relax && !quiet_ev;
      n_neg  = hit_mode.csneg && !quiet_ev && !hit_mode.dram;
      n_bst  = hit_mode.burst && burst_req;
      n_len  = hit_mode.len;
      n_off  = addr_lw;
    end else if (end_ev) begin
      n_busy = 1'b0;
    end else if (busy) begin
      n_ph = ph + PH_W'(1);
    end
    n_tot   = cycle_phases(n_len, n_rlx, n_bst);
    act_row = n_busy && n_ph >= first_phase(ST_SEL, n_rlx) && n_ph < n_tot;
    act_sel = act_row && !n_dram && n_ph < n_tot - (n_neg ? PH_W'(1) : PH_W'(0));
    act_mux = n_busy && n_dram && n_ph >= first_phase(ST_MUX, n_rlx) && n_ph < n_tot;
    act_col = n_busy && n_dram && n_ph >= first_phase(ST_COL, n_rlx) && n_ph < n_tot;
    bank_1h = NB'(1) << n_bank;
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      bclk <= 1'b0; busy <= 1'b0; ph <= '0; bank <= '0;
      dram <= 1'b0; rlx <= 1'b0; neg <= 1'b0; bst <= 1'b0;
      len <= '0; off <= '0;
      cs_n <= '1; ras_n <= '1; cas_n <= '1; amux_n <= 1'b1;
      burst_ack_n <= 1'b1; badr <= '0; nomatch <= 1'b0;
    end else begin
      bclk <= ~bclk;
      busy <= n_busy; ph <= n_ph; bank <= n_bank; dram <= n_dram;
      rlx <= n_rlx; neg <= n_neg; bst <= n_bst; len <= n_len; off <= n_off;
      cs_n   <= ~(act_sel ? bank_1h : '0);
      ras_n  <= ~((act_row && n_dram) ? bank_1h : '0);
      cas_n  <= ~(act_col ? bank_1h : '0);
      amux_n <= ~act_mux;
      burst_ack_n <= ~(n_busy && n_bst);
      badr <= n_off + ((n_busy && n_bst) ? burst_beat(n_ph, n_tot) : 2'd0);
      if (miss_ev) nomatch <= 1'b1;
      else if (take_ev) nomatch <= 1'b0;
    end
  end

  a_r3_single_cs: assert property (@(posedge pclk) disable iff (!rst_n)
    $onehot0(~cs_n));
  a_r7_col_inside_row: assert property (@(posedge pclk) disable iff (!rst_n)
    !(|(~cas_n & ras_n)));
  a_r8_badr_step: assert property (@(posedge pclk) disable iff (!rst_n)
    (!burst_ack_n && !$past(burst_ack_n) && !$stable(badr)) |-> badr == $past(badr) + 2'd1);
  a_r4_miss_quiet: assert property (@(posedge pclk) disable iff (!rst_n)
    nomatch |-> (&cs_n && &ras_n && &cas_n && amux_n && burst_ack_n));
  a_r12_busy_start_no_flag: assert property (@(posedge pclk) disable iff (!rst_n)
    (busy && !end_ev && !nomatch) |=> !nomatch);
endmodule

// File: rtl/bank_cs_ctrl.sv
module bank_cs_ctrl
  import bcs_pkg::*;
#(
  parameter int NB = 4,
  localparam int IDX_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                 pclk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BASE_W-1:0]    addr_hi,
  input  logic [1:0]           addr_lw,
  input  logic [FC_W-1:0]      fc,
  input  logic                 ext_master,
  input  logic                 ext_we,
  input  logic                 burst_req,
  input  logic [NB*BR_W-1:0]   cfg_br,
  input  logic [NB*OR_W-1:0]   cfg_or,
  output logic                 bclk,
  output logic [NB-1:0]        cs_n,
  output logic [NB-1:0]        ras_n,
  output logic [NB-1:0]        cas_n,
  output logic                 amux_n,
  output logic                 burst_ack_n,
  output logic [1:0]           badr,
  output logic                 nomatch,
  output logic [NB-1:0]        cfg_err
);
  logic [NB-1:0]    hits;
  mode_t            modes [NB];
  logic             any_hit, full_cmp;
  logic [IDX_W-1:0] hit_idx;
  mode_t            sel_mode;

  assign full_cmp = ext_master && !ext_we;

  for (genvar i = 0; i < NB; i++) begin : g_bank
    bcs_bank_match u_match (
      .br      (cfg_br[i*BR_W +: BR_W]),
      .opt     (cfg_or[i*OR_W +: OR_W]),
      .addr_hi (addr_hi),
      .fc      (fc),
      .full_cmp(full_cmp),
      .hit     (hits[i]),
      .cfg_err (cfg_err[i]),
      .mode    (modes[i])
    );
  end

  bcs_pick #(.N(NB)) u_pick (.req(hits), .any(any_hit), .idx(hit_idx));

  assign sel_mode = modes[hit_idx];

  bcs_seq #(.NB(NB), .IDX_W(IDX_W)) u_seq (
    .pclk       (pclk),
    .rst_n      (rst_n),
    .start      (start),
    .any_hit    (any_hit),
    .hit_idx    (hit_idx),
    .hit_mode   (sel_mode),
    .ext_master (ext_master),
    .burst_req  (burst_req),
    .addr_lw    (addr_lw),
    .bclk       (bclk),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .amux_n     (amux_n),
    .burst_ack_n(burst_ack_n),
    .badr       (badr),
    .nomatch    (nomatch)
  );
endmodule

// File: tb/bank_cs_ctrl_bench.sv
module bank_cs_ctrl_bench;
  localparam int PCLK_PERIOD = 10;
  localparam int NB = 4;

  logic pclk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [20:0] addr_hi = '0;
  logic [1:0] addr_lw = '0;
  logic [3:0] fc = '0;
  logic ext_master = 1'b0, ext_we = 1'b0, burst_req = 1'b0;
  logic [NB*29-1:0] cfg_br;
  logic [NB*10-1:0] cfg_or;
  logic bclk, amux_n, burst_ack_n, nomatch;
  logic [NB-1:0] cs_n, ras_n, cas_n, cfg_err;
  logic [1:0] badr;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [20:0] b_base [NB] = '{21'h0A001, 21'h0A002, 21'h1B003, 21'h0A001};
  logic [3:0]  b_fc   [NB] = '{4'h5, 4'h0, 4'h8, 4'h0};
  logic [3:0]  b_fcm  [NB] = '{4'hF, 4'h0, 4'h8, 4'h0};
  logic [3:0]  b_len  [NB] = '{4'd1, 4'd0, 4'd0, 4'd1};
  bit b_dram [NB] = '{0, 0, 1, 1};
  bit b_rlx  [NB] = '{0, 1, 0, 1};
  bit b_neg  [NB] = '{0, 1, 0, 0};
  bit b_sync [NB] = '{1, 0, 1, 1};
  bit b_bst  [NB] = '{0, 0, 1, 1};

  bank_cs_ctrl #(.NB(NB)) u_bank_cs_ctrl (
    .pclk(pclk), .rst_n(rst_n), .start(start), .addr_hi(addr_hi), .addr_lw(addr_lw),
    .fc(fc), .ext_master(ext_master), .ext_we(ext_we), .burst_req(burst_req),
    .cfg_br(cfg_br), .cfg_or(cfg_or), .bclk(bclk), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .amux_n(amux_n), .burst_ack_n(burst_ack_n), .badr(badr),
    .nomatch(nomatch), .cfg_err(cfg_err));

  always #(PCLK_PERIOD/2) pclk = ~pclk;

  always_comb
    for (int i = 0; i < NB; i++) begin
      cfg_br[i*29 +: 29] = {b_base[i], b_fc[i], b_bst[i], b_rlx[i], b_dram[i], 1'b1};
      cfg_or[i*10 +: 10] = {b_sync[i], b_neg[i], b_len[i], b_fcm[i]};
    end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // lowest bank satisfying R1 and R2, or -1
  function automatic int model_bank(logic [20:0] a, logic [3:0] f, bit ext, bit we);
    for (int i = 0; i < NB; i++) begin
      bit need_top = ext && !we;
      bit top_ok = (a >> 17) == (b_base[i] >> 17);
      bit low_ok = (a % (1 << 17)) == (b_base[i] % (1 << 17));
      bit code_ok = ((f ^ b_fc[i]) & b_fcm[i]) == 4'h0;
      if (low_ok && (top_ok || !need_top) && code_ok) return i;
    end
    return -1;
  endfunction

  task automatic access(input logic [20:0] a, input logic [1:0] lw, input logic [3:0] f,
                        input bit ext, input bit we, input bit breq, input bit poke);
    int eb, tlen, r, n, dr, b, q;
    string tag;
    eb = model_bank(a, f, ext, we);
    r = 0; n = 0; dr = 0; b = 0; tlen = 2;
    if (eb >= 0) begin
      dr = b_dram[eb];
      q = (ext && !b_sync[eb] && !dr) ? 1 : 0;
      r = (b_rlx[eb] && !q) ? 1 : 0;
      n = (b_neg[eb] && !q && !dr) ? 1 : 0;
      b = (b_bst[eb] && breq) ? 1 : 0;
      tlen = 4 + 2 * int'(b_len[eb]) + 2 * r + (b ? 6 : 0);
      tag = dr ? "R7" : (q ? "R10" : (r ? "R6" : "R5"));
    end else tag = "R4";
    if (poke) tag = {tag, " R12"};
    @(negedge pclk);
    while (bclk) @(negedge pclk);
    addr_hi = a; addr_lw = lw; fc = f; ext_master = ext; ext_we = we; burst_req = breq;
    start = 1'b1;
    @(negedge pclk);
    start = 1'b0;
    for (int k = 0; k <= tlen + 1; k++) begin
      logic [3:0] ecs, eras, ecas;
      logic eam, eack;
      int beat;
      ecs = 4'hF; eras = 4'hF; ecas = 4'hF; eam = 1'b1; eack = 1'b1; beat = 0;
      if (eb >= 0 && k < tlen) begin
        if (!dr && k >= 1 + r && k < tlen - n) ecs[eb] = 1'b0;
        if (dr && k >= 1 + r) eras[eb] = 1'b0;
        if (dr && k >= 2 + 2 * r) eam = 1'b0;
        if (dr && k >= 3 + 2 * r) ecas[eb] = 1'b0;
        if (b) eack = 1'b0;
        if (b && k >= tlen - 6) beat = (k - (tlen - 6)) / 2 + 1;
      end
      check({tag, " cs_n bank select R1 R2 R3"}, 32'(cs_n), 32'(ecs));
      check({tag, " ras_n"}, 32'(ras_n), 32'(eras));
      check({tag, " cas_n"}, 32'(cas_n), 32'(ecas));
      check({tag, " amux_n"}, 32'(amux_n), 32'(eam));
      check(b ? "R8 burst ack" : "R9 no burst ack", 32'(burst_ack_n), 32'(eack));
      check({tag, " R4 nomatch"}, 32'(nomatch), 32'(eb < 0));
      if (eb >= 0 && k < tlen)
        check("R8 badr", 32'(badr), 32'((int'(lw) + beat) % 4));
      if (poke && k == 1) begin
        addr_hi = 21'h00001; start = 1'b1;
      end
      if (poke && k == 2) start = 1'b0;
      @(negedge pclk);
    end
  endtask

  initial begin
    repeat (3) @(posedge pclk);
    @(negedge pclk);
    rst_n = 1'b1;
    @(negedge pclk);
    check("R4 reset cs_n", 32'(cs_n), 32'hF);
    check("R4 reset ras_n", 32'(ras_n), 32'hF);
    check("R4 reset cas_n", 32'(cas_n), 32'hF);
    check("R4 reset amux/ack", 32'({amux_n, burst_ack_n}), 32'h3);
    check("R4 reset nomatch", 32'(nomatch), 32'h0);
    check("R11 cfg_err", 32'(cfg_err), 32'h2);
    for (int f = 0; f < 16; f++)
      for (int m = 0; m < 3; m++)
        for (int ai = 0; ai < 9; ai++)
          for (int br = 0; br < 2; br++) begin
            logic [20:0] a;
            if (ai < 4) a = b_base[ai];
            else if (ai < 8) a = b_base[ai-4] ^ 21'h100000;
            else a = 21'h00001;
            access(a, 2'(ai), 4'(f), m != 0, m == 1, br != 0, (f == 3) && (br != 0));
          end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge pclk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule